// File: doc/BRIEF.md
# Three-Channel Interval Timer with Dual Compare

This block holds three independent 32-bit timers behind a single word-wide register bus. Each timer has a live counter, a reload value and two compare values. A timer advances either on every clock cycle or on each rising edge of a shared external tick, and it can count up or down. When a count wraps (past all ones going up, past zero going down), the timer reloads from its reload register.

The block records three kinds of event for every timer in one shared sticky event word: compare-A hit, compare-B hit and wrap. A shared mask word decides which of these events drive the single interrupt line. Software clears events by writing ones to the event word. Software reads or writes every register with a one-cycle write strobe, and reads return combinationally.

Top module: `tmr3_block`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Timer n (n = 1..3) exposes four read/write words at byte address (n-1)*0x10: counter +0x0, reload +0x4, compare-A +0x8, compare-B +0xC. The event word reads back only bits 8:0 and the mask word only bits 8:0. A word address at or above 0x3C, or one with address bits 1:0 not zero, reads 0.
- R3: The control word is at 0x30. For timer n: bit 3(n-1) is run, bit 3(n-1)+1 is tick select (1 = external tick), bit 3(n-1)+2 is wrap-event enable, and bit 9+(n-1) is direction (1 = down). Only bits 11:0 read back.
- R4: A running timer with tick select 0 changes by exactly one on each clock. A stopped timer holds its value.
- R5: Counting up, a tick taken at 0xFFFFFFFF loads the reload value instead.
- R6: Counting down, a tick taken at 0 loads the reload value instead.
- R7: Event bit 3(n-1)+2 of the event word (0x34) is set on a wrap only while the wrap-event enable is 1.
- R8: When a tick moves the counter to a value equal to compare-A (or compare-B), event bit 3(n-1) (or 3(n-1)+1) is set and stays set.
- R9: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. An event that occurs in the same cycle as a clear wins.
- R10: The mask word is at 0x38, with the event-word layout. `irq` is high exactly when some event bit is set whose mask bit is 0.
- R11: With tick select 1, the timer advances once per rising edge of `ext_tick`, after a two-stage synchronizer. A level held high counts only once.
- R12: A bus write to a counter in the same cycle as a tick takes priority. The counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ext_tick | input | 1 | Asynchronous external tick |
| irq | output | 1 | Combined masked interrupt |

## Verification
The counting function is exercised in four ways:
- An up-counting run on the internal clock crosses compare-A, which separates per-cycle advance from a stuck counter and shows the compare latch.
- A down-counting run with a small reload wraps twice through zero, which shows the reload path, the wrap event and a compare-B hit on the reloaded value.
- An up-counting run that starts just below all ones with the wrap event disabled shows the reload happening while the wrap event is suppressed.
- The external-tick run uses short pulses, a long held level and an idle stretch, which separates edge counting from level counting.

A counter write during a running count shows that the write takes priority over the tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_CW   = 32;
    localparam int TMR_AW   = 8;
    localparam logic [TMR_AW-1:0] ADR_CTRL  = 8'h30;
    localparam logic [TMR_AW-1:0] ADR_EVENT = 8'h34;
    localparam logic [TMR_AW-1:0] ADR_MASK  = 8'h38;

    typedef struct packed {
        logic [TMR_CW-1:0] cnt;
        logic [TMR_CW-1:0] reload;
        logic [TMR_CW-1:0] cmp_a;
        logic [TMR_CW-1:0] cmp_b;
    } chan_regs_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_regs_t;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    import tmr_pkg::*;

    sync_regs_t q, d;

    always_comb begin
        d      = q;
        d.s1   = async_in;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_pulse = q.s2 & ~q.prev;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                wr_sel,
    input  logic [tmr_pkg::TMR_CW-1:0] wdata,
    input  logic                      tick,
    input  logic                      dir_down,
    input  logic                      wrap_en,
    output logic [tmr_pkg::TMR_CW-1:0] cnt,
    output logic [tmr_pkg::TMR_CW-1:0] reload,
    output logic [tmr_pkg::TMR_CW-1:0] cmp_a,
    output logic [tmr_pkg::TMR_CW-1:0] cmp_b,
    output logic                      ev_cmp_a,
    output logic                      ev_cmp_b,
    output logic                      ev_wrap
);
    import tmr_pkg::*;

    localparam logic [TMR_CW-1:0] ALL_ONES = '1;

    chan_regs_t q, d;
    logic       wrap;

    always_comb begin
        d        = q;
        wrap     = 1'b0;
        ev_cmp_a = 1'b0;
        ev_cmp_b = 1'b0;
        if (wr_sel[1]) d.reload = wdata;
        if (wr_sel[2]) d.cmp_a  = wdata;
        if (wr_sel[3]) d.cmp_b  = wdata;
        if (wr_sel[0]) begin
            d.cnt = wdata;
        end else if (tick) begin
            if (dir_down) begin
                if (q.cnt == '0) begin
                    d.cnt = q.reload;
                    wrap  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end else begin
                if (q.cnt == ALL_ONES) begin
                    d.cnt = q.reload;
                    wrap  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ev_cmp_a = (d.cnt == q.cmp_a);
            ev_cmp_b = (d.cnt == q.cmp_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ev_wrap = wrap & wrap_en;
    assign cnt     = q.cnt;
    assign reload  = q.reload;
    assign cmp_a   = q.cmp_a;
    assign cmp_b   = q.cmp_b;
endmodule

// File: rtl/tmr3_block.sv
module tmr3_block #(
    parameter int NUM_TMR = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ext_tick,
    output logic        irq
);
    import tmr_pkg::*;

    localparam int EV_W  = 3 * NUM_TMR;
    localparam int CTL_W = 4 * NUM_TMR;
    localparam int DIR_B = 3 * NUM_TMR;

    typedef struct packed {
        logic [CTL_W-1:0] ctrl;
        logic [EV_W-1:0]  events;
        logic [EV_W-1:0]  mask;
    } top_regs_t;

    top_regs_t q, d;

    logic                  ext_rise;
    logic                  wr_strobe;
    logic                  word_ok;
    logic [EV_W-1:0]       ev_set;
    logic [TMR_CW-1:0]     cnt_a    [NUM_TMR];
    logic [TMR_CW-1:0]     reload_a [NUM_TMR];
    logic [TMR_CW-1:0]     cmpa_a   [NUM_TMR];
    logic [TMR_CW-1:0]     cmpb_a   [NUM_TMR];
    logic [NUM_TMR*TMR_CW-1:0] cnt_flat;
    logic [CTL_W-1:0]      ctrl_w;
    logic [EV_W-1:0]       events_w;
    logic [EV_W-1:0]       mask_w;

    assign wr_strobe = bus_en & bus_we;
    assign word_ok   = (bus_addr[1:0] == 2'b00);

    tmr_tick_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ext_tick),
        .rise_pulse (ext_rise)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
        logic [3:0] sel;
        logic       tick;
        logic       e_a, e_b, e_w;

        for (genvar k = 0; k < 4; k++) begin : g_sel
            assign sel[k] = wr_strobe && word_ok &&
                            (bus_addr[7:4] == 4'(t)) && (bus_addr[3:2] == 2'(k));
        end

        assign tick = q.ctrl[3*t] & (q.ctrl[3*t+1] ? ext_rise : 1'b1);

        tmr_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel),
            .wdata    (bus_wdata),
            .tick     (tick),
            .dir_down (q.ctrl[DIR_B+t]),
            .wrap_en  (q.ctrl[3*t+2]),
            .cnt      (cnt_a[t]),
            .reload   (reload_a[t]),
            .cmp_a    (cmpa_a[t]),
            .cmp_b    (cmpb_a[t]),
            .ev_cmp_a (e_a),
            .ev_cmp_b (e_b),
            .ev_wrap  (e_w)
        );

        assign ev_set[3*t]   = e_a;
        assign ev_set[3*t+1] = e_b;
        assign ev_set[3*t+2] = e_w;
        assign cnt_flat[t*TMR_CW +: TMR_CW] = cnt_a[t];
    end

    always_comb begin
        d = q;
        if (wr_strobe && word_ok && bus_addr == ADR_CTRL) d.ctrl = bus_wdata[CTL_W-1:0];
        if (wr_strobe && word_ok && bus_addr == ADR_MASK) d.mask = bus_wdata[EV_W-1:0];
        d.events = q.events;
        if (wr_strobe && word_ok && bus_addr == ADR_EVENT)
            d.events = q.events & ~bus_wdata[EV_W-1:0];
        d.events = d.events | ev_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (word_ok) begin
            if (bus_addr == ADR_CTRL) begin
                bus_rdata[CTL_W-1:0] = q.ctrl;
            end else if (bus_addr == ADR_EVENT) begin
                bus_rdata[EV_W-1:0] = q.events;
            end else if (bus_addr == ADR_MASK) begin
                bus_rdata[EV_W-1:0] = q.mask;
            end else begin
                for (int t = 0; t < NUM_TMR; t++) begin
                    if (bus_addr[7:4] == 4'(t)) begin
                        case (bus_addr[3:2])
                            2'd0:    bus_rdata = cnt_a[t];
                            2'd1:    bus_rdata = reload_a[t];
                            2'd2:    bus_rdata = cmpa_a[t];
                            default: bus_rdata = cmpb_a[t];
                        endcase
                    end
                end
            end
        end
    end

    assign irq      = |(q.events & ~q.mask);
    assign ctrl_w   = q.ctrl;
    assign events_w = q.events;
    assign mask_w   = q.mask;
endmodule

// File: rtl/tmr3_checks.sv
module tmr3_checks #(
    parameter int NUM_TMR = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_en,
    input logic                     bus_we,
    input logic [7:0]               bus_addr,
    input logic [31:0]              bus_wdata,
    input logic                     irq,
    input logic [4*NUM_TMR-1:0]     ctrl_w,
    input logic [3*NUM_TMR-1:0]     events_w,
    input logic [3*NUM_TMR-1:0]     mask_w,
    input logic [NUM_TMR*32-1:0]    cnt_flat
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (!irq && events_w == '0 && mask_w == '0 && ctrl_w == '0);
        end
    end

    a_r10_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (events_w != '0));

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
        a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_w[3*t] && !(bus_en && bus_we && bus_addr == 8'(t*16)))
            |=> $stable(cnt_flat[t*32 +: 32]));

        a_r7_no_wrap_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_w[3*t+2] |=> !$rose(events_w[3*t+2]));
    end

    for (genvar b = 0; b < 3*NUM_TMR; b++) begin : g_b
        a_r9_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(events_w[b]) |->
            $past(bus_en && bus_we && bus_addr == 8'h34 && bus_wdata[b]));
    end
endmodule

bind tmr3_block tmr3_checks #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ctrl_w    (ctrl_w),
    .events_w  (events_w),
    .mask_w    (mask_w),
    .cnt_flat  (cnt_flat)
);

// File: tb/tmr3_block_bench.sv
module tmr3_block_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q_exp[$];
    event  rd_ev;

    always #2 clk = ~clk;

    tmr3_block u_tmr3_block (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    // monitor: pops an expected item per read and compares
    initial begin
        forever begin
            @(rd_ev);
            #1;
            if (q_exp.size() > 0) begin
                item_t it;
                it = q_exp.pop_front();
                n_cmp++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read 0x%08h expected 0x%08h", it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    // all tasks are called at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.exp = e; it.req = req;
        q_exp.push_back(it);
        bus_addr = a;
        -> rd_ev;
        #2;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string req);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq %0b expected %0b", req, irq, e);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h00, 32'h0, "R1 counter1");
        rd(8'h30, 32'h0, "R1 ctrl");
        rd(8'h34, 32'h0, "R1 events");
        rd(8'h38, 32'h0, "R1 mask");
        chk_irq(1'b0, "R1 irq");

        // R2 register file
        wr(8'h14, 32'hA5A5_0001);
        wr(8'h28, 32'h1234_5678);
        wr(8'h2C, 32'hDEAD_BEEF);
        rd(8'h14, 32'hA5A5_0001, "R2 reload2");
        rd(8'h28, 32'h1234_5678, "R2 cmpA3");
        rd(8'h2C, 32'hDEAD_BEEF, "R2 cmpB3");
        rd(8'h3C, 32'h0, "R2 unmapped 0x3C");
        rd(8'h2D, 32'h0, "R2 unaligned");
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, 32'h0000_01FF, "R2 mask width");
        wr(8'h38, 32'h0);

        // R3 ctrl readback: direction bits only, timers stopped
        wr(8'h30, 32'hFFFF_FE00);
        rd(8'h30, 32'h0000_0E00, "R3 ctrl width");
        wr(8'h30, 32'h0);

        // R4/R8 timer1 up, internal clock, cmpA=5
        wr(8'h08, 32'd5);
        wr(8'h00, 32'd0);
        wr(8'h30, 32'h001);
        wait_n(10);
        wr(8'h30, 32'h0);              // 11 ticks in total
        rd(8'h00, 32'd11, "R4 up count");
        rd(8'h00, 32'd11, "R4 stopped holds");
        rd(8'h34, 32'h001, "R8 cmpA event t1");
        wr(8'h34, 32'h001);
        rd(8'h34, 32'h0, "R9 write-one clear");

        // R6/R7/R8 timer2 down, reload 3, start 2, cmpB=3
        wr(8'h14, 32'd3);
        wr(8'h10, 32'd2);
        wr(8'h18, 32'd9);
        wr(8'h1C, 32'd3);
        wr(8'h30, 32'h428);
        wait_n(6);
        wr(8'h30, 32'h0);              // 7 ticks: 1 0 3 2 1 0 3
        rd(8'h10, 32'd3, "R6 down wrap reload");
        rd(8'h34, 32'h030, "R7 wrap event and R8 cmpB t2");

        // R5/R7 timer3 up across all ones, wrap event disabled
        wr(8'h24, 32'h10);
        wr(8'h20, 32'hFFFF_FFFE);
        wr(8'h30, 32'h040);
        wait_n(2);
        wr(8'h30, 32'h0);              // 3 ticks: FFFFFFFF 10 11
        rd(8'h20, 32'h11, "R5 up wrap reload");
        rd(8'h34, 32'h030, "R7 no wrap event when disabled");

        // R10 masking
        chk_irq(1'b1, "R10 unmasked events");
        wr(8'h38, 32'h030);
        chk_irq(1'b0, "R10 all masked");
        wr(8'h38, 32'h020);
        chk_irq(1'b1, "R10 one unmasked");
        wr(8'h34, 32'h010);
        rd(8'h34, 32'h020, "R9 partial clear");
        chk_irq(1'b0, "R10 remaining masked");
        wr(8'h34, 32'h1FF);
        wr(8'h38, 32'h0);
        chk_irq(1'b0, "R10 no events");

        // R11 external tick on timer1
        wr(8'h00, 32'd100);
        wr(8'h30, 32'h003);
        wait_n(20);
        rd(8'h00, 32'd100, "R11 no edges no advance");
        for (int i = 0; i < 5; i++) begin
            ext_tick = 1'b1; wait_n(4);
            ext_tick = 1'b0; wait_n(4);
        end
        rd(8'h00, 32'd105, "R11 five edges");
        ext_tick = 1'b1; wait_n(20);
        ext_tick = 1'b0; wait_n(5);
        rd(8'h00, 32'd106, "R11 held level counts once");

        // R12 write beats tick on a running timer
        wr(8'h30, 32'h001);
        wr(8'h00, 32'h100);
        rd(8'h00, 32'h100, "R12 write wins");
        rd(8'h00, 32'h101, "R12 then counts");
        wr(8'h30, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
                wait (q_exp.size() == 0);
                #10;
            end
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule